// File: doc/BRIEF.md
# Four-Lane Loopback Self-Test Engine

This block is the built-in self-test engine of a four-lane serial retimer. A single pattern source drives the same symbol stream onto every lane; an internal loopback returns each lane to its own checker. Each checker compares the stream against the pattern it expects, then counts received frames and the frames that held at least one wrong symbol. A 16-bit register port sets up the test, starts and stops it, and reads back the results. This port stands in for a management bus.

Software writes the control register with a pattern type, a symbol width, enable and start. After a while it sets the stop bit and polls until that bit reads 0. It then reads the transmit count and the per-lane receive and error counts. A lane passes when its error count is zero and its receive count is non-zero. Stop only acts at a frame boundary, so every counted frame is whole. An input per lane flips bit 0 of every looped-back symbol on that lane. This models a faulty channel.

Top module: `lane_bist_engine`

## Requirements
- R1: After reset every readable register returns 0.
- R2: Control register (address 0) fields: bits 11:10 pattern kind, bit 12 ten-bit symbols (1) or eight-bit symbols (0), bit 13 enable, bit 14 stop, bit 15 start. A write with bits 15 and 13 both set starts a test from idle, and bit 15 then reads 1. A start write with bit 13 clear is ignored.
- R3: With no channel fault, every pattern kind passes in both symbol widths. Kind 0 is a counting pattern, 1 is a scrambled counting pattern, 2 is a block pattern with alternating transition density, and 3 is PRBS-7 (x^7+x^6+1). Each lane shows zero errors and a non-zero receive count.
- R4: Writing bit 14 = 1 clears bit 15 at once. Bit 14 reads 1 until the last frame has gone through the loopback and been counted, then reads 0. When issued while idle, it clears one cycle later.
- R5: Only whole frames of FRAME_SYMS symbols are sent. The test sends one symbol per cycle from the cycle after the start write. If the stop write is taken S cycles after the start write, the transmit count is ceil((S+1)/FRAME_SYMS).
- R6: Each lane's received-frame count equals the transmit count after the stop completes, and never exceeds it.
- R7: A frame with any mismatching symbol adds exactly one to that lane's error count. With the fault input of one lane held high, that lane's error count equals its receive count, and the other lanes show 0.
- R8: All counters saturate at 2^CNT_W-1.
- R9: Counters clear when a new test starts and hold their values while idle.
- R10: A control write with bit 13 clear aborts a running test. Bits 15 and 14 read 0, and the counters stop changing.
- R11: Address 1 is the transmit count, 2+l is lane l's receive count, and 6+l is lane l's error count. Other addresses read 0, and writes to counter addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational on reg_addr) |
| loop_fault | input | NLANES | Per-lane fault: flips bit 0 of every looped symbol |

## Verification
A wrong generator or checker state shows as a non-zero error count on a clean channel, or as a zero count on a faulty one. This is visible once the stop bit clears, which is at most FRAME_SYMS+LOOP_LAT cycles after the stop write. A fault in the control sequencing shows in the transmit count, which is off from the ceiling formula of R5. It also shows as a stop bit that clears before the receive counts have caught up. Saturation and clearing errors show as counts above the limit, or as stale values after a restart.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} bist_state_e;

  // PRBS-7, x^7 + x^6 + 1
  function automatic logic [6:0] prbs7_next(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  function automatic logic [9:0] prbs7_sym(input logic [6:0] s);
    return {s[2:0], s};
  endfunction

  function automatic logic [9:0] pat_sym(input logic [1:0] kind, input logic [9:0] idx,
                                         input logic [6:0] prbs);
    logic [9:0] r;
    case (kind)
      2'd0:    r = idx;
      2'd1:    r = (idx * 10'd71) ^ 10'h2B5;
      2'd2:    r = idx[3] ? 10'h17C : 10'h283;
      default: r = prbs7_sym(prbs);
    endcase
    return r;
  endfunction

  function automatic logic [9:0] sym_mask(input logic b10, input logic [9:0] s);
    return b10 ? s : {2'b00, s[7:0]};
  endfunction
endpackage

// File: rtl/bist_sat_ctr.sv
module bist_sat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAXV && !clr) |=> (q == MAXV));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(q));
endmodule

// File: rtl/bist_patgen.sv
module bist_patgen
  import bist_pkg::*;
#(
  parameter int FRAME_SYMS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       adv,
  input  logic [1:0] kind,
  input  logic       b10,
  output logic [9:0] sym,
  output logic       frame_end
);
  localparam int POS_W = (FRAME_SYMS > 1) ? $clog2(FRAME_SYMS) : 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_SYMS - 1);

  logic [9:0]       idx;
  logic [6:0]       prbs;
  logic [POS_W-1:0] pos;

  assign sym       = sym_mask(b10, pat_sym(kind, idx, prbs));
  assign frame_end = adv && (pos == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      idx  <= '0;
      prbs <= 7'h7F;
      pos  <= '0;
    end else if (adv) begin
      idx  <= idx + 1'b1;
      prbs <= prbs7_next(prbs);
      pos  <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk
  import bist_pkg::*;
#(
  parameter int FRAME_SYMS = 8,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             rx_valid,
  input  logic [9:0]       rx_sym,
  input  logic [1:0]       kind,
  input  logic             b10,
  output logic [CNT_W-1:0] frm_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int POS_W = (FRAME_SYMS > 1) ? $clog2(FRAME_SYMS) : 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_SYMS - 1);

  logic [9:0]       idx;
  logic [POS_W-1:0] pos;
  logic [6:0]       prev;
  logic             have_prev;
  logic             bad;
  logic             take;
  logic [9:0]       exp_sym;
  logic             sym_bad;
  logic             frame_done;
  logic             frame_err;

  // PRBS kind predicts from the previous received symbol: self-synchronising
  assign exp_sym = (kind == 2'd3) ? sym_mask(b10, prbs7_sym(prbs7_next(prev)))
                                  : sym_mask(b10, pat_sym(kind, idx, 7'h00));
  assign take       = rx_valid && active;
  assign sym_bad    = take && !(kind == 2'd3 && !have_prev) && (rx_sym != exp_sym);
  assign frame_done = take && (pos == LAST);
  assign frame_err  = frame_done && (bad || sym_bad);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx       <= '0;
      pos       <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      bad       <= 1'b0;
    end else if (take) begin
      idx       <= idx + 1'b1;
      pos       <= (pos == LAST) ? '0 : pos + 1'b1;
      prev      <= rx_sym[6:0];
      have_prev <= 1'b1;
      bad       <= frame_done ? 1'b0 : (bad || sym_bad);
    end
  end

  bist_sat_ctr #(.CNT_W(CNT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(frame_done), .q(frm_cnt));
  bist_sat_ctr #(.CNT_W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(frame_err), .q(err_cnt));

  // R7
  err_le_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= frm_cnt);
endmodule

// File: rtl/lane_bist_engine.sv
module lane_bist_engine
  import bist_pkg::*;
#(
  parameter int NLANES     = 4,
  parameter int FRAME_SYMS = 8,
  parameter int CNT_W      = 16,
  parameter int LOOP_LAT   = 2,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NLANES-1:0] loop_fault
);
  localparam int RX_BASE  = 2;
  localparam int ERR_BASE = RX_BASE + NLANES;
  localparam int DR_W     = $clog2(LOOP_LAT + 1);

  bist_state_e     state;
  logic            start_r, stop_r, en_r, b10_r;
  logic [1:0]      kind_r;
  logic [DR_W-1:0] drain_cnt;

  logic wr_ctrl, abort, start_go, stop_wr;
  logic gen_adv, frame_end, active;
  logic [9:0] gen_sym;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[9:0];
  assign wr_ctrl  = reg_we && (reg_addr == '0);
  assign abort    = wr_ctrl && !reg_wdata[13];
  assign start_go = wr_ctrl && reg_wdata[15] && reg_wdata[13] && (state == ST_IDLE);
  assign stop_wr  = wr_ctrl && reg_wdata[14] && !abort;
  assign gen_adv  = (state == ST_RUN);
  assign active   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; start_r <= 1'b0; stop_r <= 1'b0; en_r <= 1'b0;
      b10_r <= 1'b0; kind_r <= 2'd0; drain_cnt <= '0;
    end else begin
      if (wr_ctrl) en_r <= reg_wdata[13];
      if (wr_ctrl && (state == ST_IDLE || abort)) begin
        kind_r <= reg_wdata[11:10];
        b10_r  <= reg_wdata[12];
      end
      if (abort) begin
        state <= ST_IDLE; start_r <= 1'b0; stop_r <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_go) begin
              state <= ST_RUN; start_r <= 1'b1;
            end
            stop_r <= stop_wr && !start_go;
          end
          ST_RUN: begin
            if (stop_wr) begin
              stop_r <= 1'b1; start_r <= 1'b0;
            end
            if (frame_end && stop_r) begin
              state <= ST_DRAIN; drain_cnt <= '0;
            end
          end
          default: begin
            drain_cnt <= drain_cnt + 1'b1;
            if (drain_cnt == DR_W'(LOOP_LAT - 1)) begin
              state <= ST_IDLE; stop_r <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  bist_patgen #(.FRAME_SYMS(FRAME_SYMS)) u_gen (
    .clk(clk), .rst_n(rst_n), .restart(start_go), .adv(gen_adv),
    .kind(kind_r), .b10(b10_r), .sym(gen_sym), .frame_end(frame_end));

  logic [CNT_W-1:0] tx_cnt;
  bist_sat_ctr #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(frame_end), .q(tx_cnt));

  // Internal loopback delay line shared by all lanes
  logic [LOOP_LAT-1:0] lb_v;
  logic [9:0]          lb_d [LOOP_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n || start_go || abort) lb_v <= '0;
    else begin
      lb_v[0] <= gen_adv;
      for (int i = 1; i < LOOP_LAT; i++) lb_v[i] <= lb_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    lb_d[0] <= gen_sym;
    for (int i = 1; i < LOOP_LAT; i++) lb_d[i] <= lb_d[i-1];
  end

  logic [CNT_W-1:0] rx_cnt  [NLANES];
  logic [CNT_W-1:0] err_cnt [NLANES];

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    bist_lane_chk #(.FRAME_SYMS(FRAME_SYMS), .CNT_W(CNT_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .clr(start_go), .active(active),
      .rx_valid(lb_v[LOOP_LAT-1]),
      .rx_sym(lb_d[LOOP_LAT-1] ^ {9'b0, loop_fault[l]}),
      .kind(kind_r), .b10(b10_r),
      .frm_cnt(rx_cnt[l]), .err_cnt(err_cnt[l]));

    // R6
    rx_le_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt[l] <= tx_cnt);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)
      reg_rdata = {start_r, stop_r, en_r, b10_r, kind_r, 10'b0};
    else if (reg_addr == ADDR_W'(1))
      reg_rdata = 16'(tx_cnt);
    for (int l = 0; l < NLANES; l++) begin
      if (reg_addr == ADDR_W'(RX_BASE + l))  reg_rdata = 16'(rx_cnt[l]);
      if (reg_addr == ADDR_W'(ERR_BASE + l)) reg_rdata = 16'(err_cnt[l]);
    end
  end

  // R4
  stop_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_r) |-> (state == ST_IDLE));

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!start_r && !stop_r && state == ST_IDLE));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (tx_cnt == '0 && start_r));
endmodule

// File: tb/test_lane_bist_engine.sv
module test_lane_bist_engine;
  localparam int F    = 4;
  localparam int CW   = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  loop_fault = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lane_bist_engine #(.NLANES(4), .FRAME_SYMS(F), .CNT_W(CW), .LOOP_LAT(2), .ADDR_W(4))
    i_lane_bist_engine (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
                        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loop_fault(loop_fault));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 v = int'(reg_rdata);
  endtask

  function automatic int exp_frames(input int s);
    int n;
    n = (s + F) / F;
    return (n > MAXC) ? MAXC : n;
  endfunction

  function automatic logic [15:0] ctrl(input bit st, input bit sp, input bit en,
                                       input bit b10, input int kind);
    return {st, sp, en, b10, 2'(kind), 10'b0};
  endfunction

  task automatic wait_stop(input string req);
    int v;
    v = 16'h4000;
    for (int i = 0; i < 64; i++) begin
      rd(0, v);
      if (v[14] == 0) break;
    end
    chk(req, v[15:14], 0);
  endtask

  // Start, run W idle cycles, stop, check counts
  task automatic run_test(input int kind, input bit b10, input int w, input logic [3:0] fm);
    int v, n;
    loop_fault = fm;
    wr(0, ctrl(1, 0, 1, b10, kind));
    repeat (w) @(negedge clk);
    wr(0, ctrl(0, 1, 1, b10, kind));
    rd(0, v);
    chk("R4 stop pending, start cleared", v[15:14], 1);
    wait_stop("R4 stop self-clears");
    n = exp_frames(w + 2);
    rd(1, v); chk("R5 tx frames", v, n);
    for (int l = 0; l < 4; l++) begin
      rd(2 + l, v); chk("R6 rx frames per lane", v, n);
      rd(6 + l, v);
      if (fm[l]) chk("R7 faulty lane errors", v, n);
      else       chk("R3 clean lane errors", v, 0);
    end
    loop_fault = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11: reset values, unmapped address
    for (int a = 0; a < 10; a++) begin
      rd(a, v); chk("R1 reset value", v, 0);
    end
    rd(12, v); chk("R11 unmapped reads 0", v, 0);

    // R2: readback during run
    wr(0, ctrl(1, 0, 1, 1, 2));
    rd(0, v); chk("R2 control readback", v, 16'hB800);
    wr(0, ctrl(0, 1, 1, 1, 2));
    wait_stop("R4 stop after readback run");

    // R3/R5/R6: sweep kinds and widths, clean channel
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++)
        run_test(k, b[0], 5 + 3 * k + 2 * b, 4'b0000);

    // R7: fault on one lane per kind
    for (int k = 0; k < 4; k++)
      run_test(k, k[0], 9 + k, 4'(1 << k));

    // R8: saturation
    run_test(0, 1'b1, 300, 4'b0010);

    // R9: clear on restart, hold while idle
    run_test(1, 1'b0, 2, 4'b0000);
    rd(1, t1);
    repeat (30) @(negedge clk);
    rd(1, t2); chk("R9 hold while idle", t2, t1);

    // R11: write to counter address ignored
    wr(1, 16'hFFFF);
    rd(1, v); chk("R11 counter write ignored", v, t1);

    // R2: start without enable ignored
    wr(0, 16'h8000);
    rd(0, v); chk("R2 start without enable ignored", v, 0);
    rd(1, v); chk("R2 counters untouched by ignored start", v, t1);

    // R4: stop while idle clears next cycle
    wr(0, ctrl(0, 1, 1, 0, 0));
    rd(0, v); chk("R4 idle stop self-clears", v, 16'h2000);

    // R10: abort
    wr(0, ctrl(1, 0, 1, 0, 3));
    repeat (10) @(negedge clk);
    wr(0, 16'h0000);
    rd(0, v); chk("R10 abort clears control", v, 0);
    rd(1, t1);
    rd(2, v);
    repeat (20) @(negedge clk);
    rd(1, t2); chk("R10 tx frozen after abort", t2, t1);
    rd(2, t2); chk("R10 rx frozen after abort", t2, v);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule